// File: doc/BRIEF.md
# Bus Error and Timeout Detector

This block sits between a processor and its two kinds of memory path: a synchronous local memory and an asynchronous backplane bus. It watches each access and raises a single error line toward the processor. That line tells the processor to take a machine check or to abandon a prefetch. It also flags interrupt-acknowledge cycles and DMA grants that got no answer, so that the bus engine can drop them.

Three reply timers share one parameterised length in clock cycles. The default is 10 microseconds at 200 MHz. The timers cover data strobes, interrupt acknowledge and DMA grant, and each one has its own outcome. A data timeout raises the error line. An acknowledge timeout raises the error line and also aborts the interrupt. A grant timeout is silent and only aborts the grant.

Parity is checked per byte on local reads, using only the lanes the byte mask enables. An error found on a direct local read is held back and reported on the next processor cycle. If that next cycle is a prefetch, it is reported on the cycle after that as well. A parity error on a local read through the backplane window, or a parity code on backplane data, is reported at once. A sticky cause register records every condition seen. Writing ones to it clears the matching bits.

Top module: `buserr_detect`

## Requirements
- R1: When `bus_din` or `bus_dout` has been sampled high on TMO_CYCLES consecutive clock edges with `bus_rply` low, `err_o` is high for exactly one clock, following the TMO_CYCLES-th edge, and does not repeat while the strobe stays high.
- R2: A `bus_rply` seen before the limit prevents the data timeout. Dropping the strobe restarts the count, so a new strobe again needs TMO_CYCLES edges.
- R3: A `cyc_start` with `cyc_nxm` high raises `err_o` for the one clock after that edge.
- R4: When `bus_iack` stays high for TMO_CYCLES edges without `bus_rply`, `err_o` and `iack_abort_o` are both high for the same single clock.
- R5: When `bus_dmg` stays high for TMO_CYCLES edges without `bus_sack`, `dma_abort_o` pulses for one clock and `err_o` stays low. A `bus_sack` before the limit prevents the abort.
- R6: On a direct local read (`lm_rd_vld` with `lm_via_win` low), a lane error counts only where `byte_mask` is set. It does not raise `err_o` in the following clock. Instead, `err_o` is high for the clock after the next `cyc_start`.
- R7: If that next cycle has `cyc_kind` = 2 (prefetch; 0 is read, 1 is write), `err_o` is also raised after the following `cyc_start`. For any other kind, it is not raised again.
- R8: When `par_en` is low, local and window parity errors are ignored. Backplane parity (R9) still raises the error.
- R9: `bus_rd_vld` with `bus_data_hi` = 2'b11 raises `err_o` in the next clock. The values 2'b01 and 2'b10 do not.
- R10: A local read through the window (`lm_via_win` high) checks both bytes of each 16-bit half that has any mask bit set. It reports in the next clock without deferral.
- R11: `cause_o` is sticky. Its bits are: bit 0 non-existent address, bit 1 data timeout, bit 2 acknowledge timeout, bit 3 grant timeout, bit 4 local or window parity, bit 5 backplane parity. Writing a one to a bit of `cause_clr` clears that bit, and a new event in the same clock wins over the clear.
- R12: After reset, `err_o`, `iack_abort_o`, `dma_abort_o` and `cause_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse at the start of a processor cycle |
| cyc_kind | input | 2 | Cycle kind: 0 read, 1 write, 2 prefetch |
| cyc_nxm | input | 1 | Address decoder finds no local target (valid with cyc_start) |
| lm_rd_vld | input | 1 | Local read data and lane parity valid |
| lm_via_win | input | 1 | That local read came through the backplane window |
| byte_mask | input | 4 | Requested byte lanes |
| lane_perr | input | 4 | Per-lane parity mismatch flags |
| par_en | input | 1 | Local parity detection enable |
| bus_rd_vld | input | 1 | Backplane read data valid |
| bus_data_hi | input | 2 | Backplane data lines 17 and 16 |
| bus_din | input | 1 | Backplane data-in strobe |
| bus_dout | input | 1 | Backplane data-out strobe |
| bus_rply | input | 1 | Backplane reply |
| bus_iack | input | 1 | Interrupt acknowledge |
| bus_dmg | input | 1 | DMA grant |
| bus_sack | input | 1 | DMA select acknowledge |
| cause_clr | input | 6 | Write-ones clear for cause bits |
| err_o | output | 1 | Error line toward the processor |
| iack_abort_o | output | 1 | Interrupt acknowledge aborted |
| dma_abort_o | output | 1 | DMA grant dropped |
| cause_o | output | 6 | Sticky cause bits |

## Verification
The assertions check, on every clock, the relations between inputs and outputs that need no long history:
- an abort of the interrupt acknowledge always comes with the error line;
- a grant abort follows an unanswered grant;
- a non-existent address or a backplane parity code raises the error line in the next clock;
- cause bits never drop without a clear.

The timed windows, the deferral of local parity across processor cycles with its prefetch follow-up, the lane masking and word widening, and the enable gating span many cycles or depend on stimulus history. Only the bench's directed scenarios show those.

// File: rtl/buserr_pkg.sv
package buserr_pkg;

    typedef enum logic [1:0] {
        CK_READ     = 2'd0,
        CK_WRITE    = 2'd1,
        CK_PREFETCH = 2'd2,
        CK_RSVD     = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PD_IDLE  = 2'd0,
        PD_ARMED = 2'd1,
        PD_LAST  = 2'd2
    } defer_st_e;

    localparam int NUM_CH   = 3;
    localparam int CH_DATA  = 0;
    localparam int CH_IACK  = 1;
    localparam int CH_DMA   = 2;
    localparam int LANES    = 4;
    localparam int CAUSE_W  = 6;

    // Packed so that nxm lands on bit 0 and bus_par on bit 5.
    typedef struct packed {
        logic bus_par;
        logic loc_par;
        logic dma_tmo;
        logic iack_tmo;
        logic data_tmo;
        logic nxm;
    } hits_t;

    // A window read checks both bytes of any half-word that is touched.
    function automatic logic [LANES-1:0] widen_mask(input logic [LANES-1:0] m);
        return {{2{|m[3:2]}}, {2{|m[1:0]}}};
    endfunction

endpackage

// File: rtl/buserr_reply_timer.sv
module buserr_reply_timer #(
    parameter int TMO_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic hit
);
    localparam int CNT_W = $clog2(TMO_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             fired;
    logic             waiting;

    assign waiting = start && !ack && !fired;
    assign hit     = waiting && (cnt == CNT_W'(TMO_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !start || ack) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (hit) begin
            cnt   <= '0;
            fired <= 1'b1;
        end else if (!fired) begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/buserr_lm_parity.sv
module buserr_lm_parity
    import buserr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic [1:0]       cyc_kind,
    input  logic             lm_rd_vld,
    input  logic             lm_via_win,
    input  logic [LANES-1:0] byte_mask,
    input  logic [LANES-1:0] lane_perr,
    input  logic             par_en,
    output logic             win_hit,
    output logic             defer_hit,
    output logic             loc_detect
);
    defer_st_e       st_q, st_d;
    logic [LANES-1:0] eff_mask;
    logic             lane_bad;
    logic             direct_bad;

    assign eff_mask   = lm_via_win ? widen_mask(byte_mask) : byte_mask;
    assign lane_bad   = lm_rd_vld && par_en && |(lane_perr & eff_mask);
    assign win_hit    = lane_bad && lm_via_win;
    assign direct_bad = lane_bad && !lm_via_win;
    assign loc_detect = lane_bad;
    assign defer_hit  = cyc_start && (st_q != PD_IDLE);

    always_comb begin
        st_d = st_q;
        if (cyc_start) begin
            unique case (st_q)
                PD_ARMED: st_d = (cyc_kind_e'(cyc_kind) == CK_PREFETCH) ? PD_LAST : PD_IDLE;
                PD_LAST:  st_d = PD_IDLE;
                default:  st_d = PD_IDLE;
            endcase
        end
        if (direct_bad) begin
            st_d = PD_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/buserr_detect.sv
module buserr_detect
    import buserr_pkg::*;
#(
    parameter int TMO_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_start,
    input  logic [1:0] cyc_kind,
    input  logic       cyc_nxm,
    input  logic       lm_rd_vld,
    input  logic       lm_via_win,
    input  logic [3:0] byte_mask,
    input  logic [3:0] lane_perr,
    input  logic       par_en,
    input  logic       bus_rd_vld,
    input  logic [1:0] bus_data_hi,
    input  logic       bus_din,
    input  logic       bus_dout,
    input  logic       bus_rply,
    input  logic       bus_iack,
    input  logic       bus_dmg,
    input  logic       bus_sack,
    input  logic [5:0] cause_clr,
    output logic       err_o,
    output logic       iack_abort_o,
    output logic       dma_abort_o,
    output logic [5:0] cause_o
);
    logic [NUM_CH-1:0] ch_start;
    logic [NUM_CH-1:0] ch_ack;
    logic [NUM_CH-1:0] ch_hit;

    assign ch_start[CH_DATA] = bus_din || bus_dout;
    assign ch_ack[CH_DATA]   = bus_rply;
    assign ch_start[CH_IACK] = bus_iack;
    assign ch_ack[CH_IACK]   = bus_rply;
    assign ch_start[CH_DMA]  = bus_dmg;
    assign ch_ack[CH_DMA]    = bus_sack;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_tmr
        buserr_reply_timer #(.TMO_CYCLES(TMO_CYCLES)) tmr_i (
            .clk   (clk),
            .rst   (rst),
            .start (ch_start[g]),
            .ack   (ch_ack[g]),
            .hit   (ch_hit[g])
        );
    end

    logic win_hit, defer_hit, loc_detect;

    buserr_lm_parity par_i (
        .clk        (clk),
        .rst        (rst),
        .cyc_start  (cyc_start),
        .cyc_kind   (cyc_kind),
        .lm_rd_vld  (lm_rd_vld),
        .lm_via_win (lm_via_win),
        .byte_mask  (byte_mask),
        .lane_perr  (lane_perr),
        .par_en     (par_en),
        .win_hit    (win_hit),
        .defer_hit  (defer_hit),
        .loc_detect (loc_detect)
    );

    hits_t hits;
    logic  raise;

    always_comb begin
        hits          = '0;
        hits.nxm      = cyc_start && cyc_nxm;
        hits.data_tmo = ch_hit[CH_DATA];
        hits.iack_tmo = ch_hit[CH_IACK];
        hits.dma_tmo  = ch_hit[CH_DMA];
        hits.loc_par  = loc_detect;
        hits.bus_par  = bus_rd_vld && (bus_data_hi == 2'b11);
        raise = hits.nxm || hits.data_tmo || hits.iack_tmo || hits.bus_par
             || win_hit || defer_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o        <= 1'b0;
            iack_abort_o <= 1'b0;
            dma_abort_o  <= 1'b0;
            cause_o      <= '0;
        end else begin
            err_o        <= raise;
            iack_abort_o <= hits.iack_tmo;
            dma_abort_o  <= hits.dma_tmo;
            cause_o      <= (cause_o & ~cause_clr) | CAUSE_W'(hits);
        end
    end

endmodule

// File: rtl/buserr_detect_chk.sv
module buserr_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       cyc_start,
    input logic       cyc_nxm,
    input logic       bus_rd_vld,
    input logic [1:0] bus_data_hi,
    input logic       bus_iack,
    input logic       bus_dmg,
    input logic       bus_sack,
    input logic [5:0] cause_clr,
    input logic       err_o,
    input logic       iack_abort_o,
    input logic       dma_abort_o,
    input logic [5:0] cause_o
);
    p_nxm_err_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_nxm) |=> err_o);

    p_iack_abort_with_err_r4: assert property (@(posedge clk) disable iff (rst)
        iack_abort_o |-> (err_o && $past(bus_iack)));

    p_dma_abort_grant_r5: assert property (@(posedge clk) disable iff (rst)
        dma_abort_o |-> ($past(bus_dmg) && !$past(bus_sack)));

    p_bus_parity_err_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_vld && bus_data_hi == 2'b11) |=> err_o);

    p_cause_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(cause_o) & ~$past(cause_clr)) & ~cause_o) == 6'd0));

endmodule

bind buserr_detect buserr_detect_chk chk_i (.*);

// File: tb/buserr_detect_tb_top.sv
`timescale 1ns/1ps
module buserr_detect_tb_top;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst;
    logic cyc_start, cyc_nxm, lm_rd_vld, lm_via_win, par_en, bus_rd_vld;
    logic [1:0] cyc_kind, bus_data_hi;
    logic [3:0] byte_mask, lane_perr;
    logic bus_din, bus_dout, bus_rply, bus_iack, bus_dmg, bus_sack;
    logic [5:0] cause_clr;
    logic err_o, iack_abort_o, dma_abort_o;
    logic [5:0] cause_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    buserr_detect #(.TMO_CYCLES(TMO)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cyc_start = 0; cyc_kind = 0; cyc_nxm = 0; lm_rd_vld = 0; lm_via_win = 0;
        byte_mask = 0; lane_perr = 0; par_en = 1; bus_rd_vld = 0; bus_data_hi = 0;
        bus_din = 0; bus_dout = 0; bus_rply = 0; bus_iack = 0; bus_dmg = 0;
        bus_sack = 0; cause_clr = 0;
    endtask

    task automatic clear_causes();
        cause_clr = 6'h3f; step(); cause_clr = 0;
    endtask

    task automatic start_cycle(input logic [1:0] kind);
        cyc_start = 1; cyc_kind = kind; step(); cyc_start = 0;
    endtask

    task automatic t_reset();
        chk("R12 err", err_o, 0);
        chk("R12 aborts", {iack_abort_o, dma_abort_o}, 0);
        chk("R12 cause", cause_o, 0);
    endtask

    task automatic t_data_timeout();
        logic seen_early = 0;
        clear_causes();
        bus_din = 1;
        for (int i = 1; i < TMO; i++) begin step(); seen_early |= err_o; end
        chk("R1 no err before limit", seen_early, 0);
        step();
        chk("R1 err at limit", err_o, 1);
        step();
        chk("R1 single pulse", err_o, 0);
        for (int i = 0; i < TMO + 2; i++) step();
        chk("R1 no repeat", err_o, 0);
        chk("R11 data cause bit1", cause_o, 6'b000010);
        bus_din = 0; step();
    endtask

    task automatic t_reply_and_restart();
        logic seen = 0;
        bus_dout = 1;
        for (int i = 0; i < TMO - 2; i++) begin step(); seen |= err_o; end
        bus_rply = 1; step(); seen |= err_o;
        bus_rply = 0; bus_dout = 0; step(); seen |= err_o;
        step(); seen |= err_o;
        chk("R2 reply prevents timeout", seen, 0);
        bus_din = 1;
        for (int i = 1; i < TMO; i++) begin step(); seen |= err_o; end
        chk("R2 restart needs full count", seen, 0);
        step();
        chk("R2 timeout after restart", err_o, 1);
        bus_din = 0; step();
    endtask

    task automatic t_nxm();
        clear_causes();
        cyc_nxm = 1; start_cycle(0); cyc_nxm = 0;
        chk("R3 nxm err", err_o, 1);
        step();
        chk("R3 nxm one clock", err_o, 0);
        chk("R11 nxm cause bit0", cause_o, 6'b000001);
    endtask

    task automatic t_iack();
        bus_iack = 1;
        for (int i = 0; i < TMO; i++) step();
        chk("R4 iack err", err_o, 1);
        chk("R4 iack abort", iack_abort_o, 1);
        step();
        chk("R4 abort single", iack_abort_o, 0);
        bus_iack = 0; step();
    endtask

    task automatic t_dma();
        logic e = 0; logic a = 0;
        clear_causes();
        bus_dmg = 1;
        for (int i = 0; i < TMO; i++) begin step(); e |= err_o; end
        chk("R5 dma abort", dma_abort_o, 1);
        chk("R5 dma silent", e, 0);
        chk("R11 dma cause bit3", cause_o, 6'b001000);
        bus_dmg = 0; step();
        bus_dmg = 1;
        for (int i = 0; i < 3; i++) step();
        bus_sack = 1;
        for (int i = 0; i < TMO + 2; i++) begin step(); a |= dma_abort_o; end
        chk("R5 sack prevents abort", a, 0);
        bus_dmg = 0; bus_sack = 0; step();
    endtask

    task automatic t_local_deferred(input logic [1:0] kind, input logic expect_again);
        lm_rd_vld = 1; byte_mask = 4'b0010; lane_perr = 4'b0010; step();
        lm_rd_vld = 0; lane_perr = 0;
        chk("R6 not reported at once", err_o, 0);
        step(); step();
        chk("R6 still quiet", err_o, 0);
        start_cycle(kind);
        chk("R6 err on next cycle", err_o, 1);
        step();
        start_cycle(0);
        chk("R7 follow-up per kind", err_o, expect_again);
        start_cycle(0);
        chk("R7 no third report", err_o, 0);
    endtask

    task automatic t_local_mask();
        lm_rd_vld = 1; byte_mask = 4'b0001; lane_perr = 4'b1110; step();
        lm_rd_vld = 0; lane_perr = 0;
        start_cycle(0);
        chk("R6 masked lane ignored", err_o, 0);
    endtask

    task automatic t_window();
        clear_causes();
        lm_rd_vld = 1; lm_via_win = 1; byte_mask = 4'b0100; lane_perr = 4'b1000; step();
        lm_rd_vld = 0; lm_via_win = 0; lane_perr = 0;
        chk("R10 widened lane err next clock", err_o, 1);
        chk("R11 local cause bit4", cause_o, 6'b010000);
        start_cycle(0);
        chk("R10 not deferred", err_o, 0);
        lm_rd_vld = 1; lm_via_win = 1; byte_mask = 4'b0001; lane_perr = 4'b0100; step();
        lm_rd_vld = 0; lm_via_win = 0; lane_perr = 0;
        chk("R10 other half ignored", err_o, 0);
    endtask

    task automatic t_par_en();
        par_en = 0;
        lm_rd_vld = 1; byte_mask = 4'b1111; lane_perr = 4'b1111; step();
        lm_rd_vld = 0; lane_perr = 0;
        start_cycle(0);
        chk("R8 local ignored when disabled", err_o, 0);
        lm_rd_vld = 1; lm_via_win = 1; lane_perr = 4'b0001; step();
        lm_rd_vld = 0; lm_via_win = 0; lane_perr = 0;
        chk("R8 window ignored when disabled", err_o, 0);
        bus_rd_vld = 1; bus_data_hi = 2'b11; step(); bus_rd_vld = 0;
        chk("R8 bus parity unaffected", err_o, 1);
        par_en = 1; step();
    endtask

    task automatic t_bus_parity();
        clear_causes();
        bus_rd_vld = 1; bus_data_hi = 2'b01; step();
        chk("R9 01 no err", err_o, 0);
        bus_data_hi = 2'b10; step();
        chk("R9 10 no err", err_o, 0);
        bus_data_hi = 2'b11; step();
        chk("R9 11 err", err_o, 1);
        bus_rd_vld = 0; bus_data_hi = 0; step();
        chk("R9 one clock", err_o, 0);
        chk("R11 bus cause bit5", cause_o, 6'b100000);
    endtask

    task automatic t_cause_clear();
        clear_causes();
        cyc_nxm = 1; start_cycle(0); cyc_nxm = 0;
        bus_rd_vld = 1; bus_data_hi = 2'b11; step(); bus_rd_vld = 0;
        chk("R11 two bits", cause_o, 6'b100001);
        cause_clr = 6'b000001; step(); cause_clr = 0;
        chk("R11 clear one bit", cause_o, 6'b100000);
        cause_clr = 6'b000001; cyc_nxm = 1; cyc_start = 1; step();
        cause_clr = 0; cyc_nxm = 0; cyc_start = 0;
        chk("R11 set wins over clear", cause_o, 6'b100001);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) step();
        rst = 0;
        t_reset();
        t_data_timeout();
        t_reply_and_restart();
        t_nxm();
        t_iack();
        t_dma();
        t_local_deferred(2'd2, 1'b1);
        t_local_deferred(2'd0, 1'b0);
        t_local_deferred(2'd1, 1'b0);
        t_local_mask();
        t_window();
        t_par_en();
        t_bus_parity();
        t_cause_clear();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule